// File: doc/BRIEF.md
# Masked-Write PHY Control Registers

This block is the control and status register file that sits between a 32-bit register bus and the analog front end of a storage-interface PHY. It holds seven 16-bit control words and presents one read-only status word. The bus is a plain address, write-enable, write-data and read-data interface. A write takes effect at the clock edge. A read returns the addressed word combinationally in the same cycle.

Each write carries its own bit mask. The upper half of the write data selects which bits of the lower half are updated, and every other bit keeps its value. Software can therefore change one field, such as the DLL enable, without first reading the word back. The decoded control fields leave the block on dedicated pins:

- power-up
- DLL enable
- DLL frequency range
- drive strength
- output tap delay enable and value
- strobe pull-down

Two completion flags from the PHY are resynchronised into the clock domain and appear in the status word.

Top module: `phy_ctl_regs`

## Requirements
- R1: After reset every control word reads 0, so every control pin is 0: the PHY is powered down, the DLL is off and the drive code is 0 (50 ohm).
- R2: A write to a control word sets bit x (x in 0..15) to bit x of the write data only when write-data bit x+16 is 1. Bits whose mask bit is 0 keep their value.
- R3: Bits 31:16 of every control word always read back as 0, whatever mask and data were written.
- R4: Word 0x18 drives three pins. Bit 0 drives `pwr_up_o` (1 = powered). Bit 1 drives `dll_en_o`. Bits 6:4 drive `drive_sel_o`, with codes 0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm and 4 = 40 ohm.
- R5: Word 0x00 drives three fields. Bits 13:12 drive `freq_sel_o`, with codes 0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz and 3 = 150 MHz. Bit 11 drives `tap_dly_en_o`. Bits 10:7 drive `tap_dly_o`.
- R6: Word 0x08 bit 9 drives `strobe_pd_o`.
- R7: The status word at 0x20 reads calibration-done in bit 6 and DLL-ready in bit 5. Every other status bit reads 0. Each flag passes through two flops, so a level present at clock edge k is readable after edge k+1.
- R8: A write to 0x20, to 0x1C, to any offset above 0x20, or to a non-word-aligned offset changes no stored bit. A read of any such offset, other than 0x20, returns 0.
- R9: Words 0x04, 0x0C, 0x10 and 0x14 store and read back all 16 low bits under the same masked-write rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Bits 31:16 are the write mask, bits 15:0 the data |
| rdata_o | output | 32 | Read data for addr_i |
| cal_done_i | input | 1 | Calibration complete, asynchronous |
| dll_ready_i | input | 1 | DLL locked, asynchronous |
| pwr_up_o | output | 1 | PHY power-up |
| dll_en_o | output | 1 | DLL enable |
| freq_sel_o | output | 2 | DLL frequency range code |
| drive_sel_o | output | 3 | Output drive strength code |
| tap_dly_en_o | output | 1 | Output tap delay enable |
| tap_dly_o | output | 4 | Output tap delay value |
| strobe_pd_o | output | 1 | Strobe line pull-down enable |

## Verification
The status-latency properties take two things for granted about the flag inputs:
- the flags are low while reset is asserted, since they compare a read against the flag level two edges earlier;
- the flags change only away from the clock edge.

The bench keeps both flags at 0 through reset. It changes them only on the falling edge, at the same point where it applies bus stimulus. The masked-write properties assume that one bus access happens per cycle. The stimulus exercises full, partial, empty and single-field masks, and it aims writes at every unmapped and misaligned class of offset.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int DATA_W   = 32;
  localparam int HALF_W   = DATA_W / 2;

  // word indices (byte offset / 4)
  localparam int IDX_TIMING = 0;
  localparam int IDX_STROBE = 2;
  localparam int IDX_POWER  = 6;

  // power word fields
  localparam int B_PWR_UP   = 0;
  localparam int B_DLL_EN   = 1;
  localparam int B_DRV_LO   = 4;
  localparam int DRV_W      = 3;

  // timing word fields
  localparam int B_TAP_LO   = 7;
  localparam int TAP_W      = 4;
  localparam int B_TAP_EN   = 11;
  localparam int B_FREQ_LO  = 12;
  localparam int FREQ_W     = 2;

  // strobe word field
  localparam int B_STRB_PD  = 9;

  // status word fields
  localparam int B_ST_DLL   = 5;
  localparam int B_ST_CAL   = 6;

  typedef enum logic [DRV_W-1:0] {
    DRV_50 = 3'd0, DRV_33 = 3'd1, DRV_66 = 3'd2, DRV_100 = 3'd3, DRV_40 = 3'd4
  } drive_code_e;

  typedef enum logic [FREQ_W-1:0] {
    FRQ_200 = 2'd0, FRQ_50 = 2'd1, FRQ_100 = 2'd2, FRQ_150 = 2'd3
  } freq_code_e;
endpackage

// File: rtl/phy_ctl_word.sv
module phy_ctl_word #(
  parameter int HALF_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [2*HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0]   q_o
);
  logic [HALF_W-1:0] mask;
  logic [HALF_W-1:0] val;

  assign mask = wdata_i[2*HALF_W-1:HALF_W];
  assign val  = wdata_i[HALF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= (q_o & ~mask) | (val & mask);
  end
endmodule

// File: rtl/phy_ctl_sync.sv
module phy_ctl_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
  import phy_ctl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_CTRL    = 7,
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_OFF  = 32'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cal_done_i,
  input  logic              dll_ready_i,
  output logic              pwr_up_o,
  output logic              dll_en_o,
  output logic [FREQ_W-1:0] freq_sel_o,
  output logic [DRV_W-1:0]  drive_sel_o,
  output logic              tap_dly_en_o,
  output logic [TAP_W-1:0]  tap_dly_o,
  output logic              strobe_pd_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0]  NUM_CTRL_L   = IDX_W'(NUM_CTRL);
  localparam logic [ADDR_W-1:0] STATUS_OFF_L = ADDR_W'(STATUS_OFF);

  logic [IDX_W-1:0]  ctrl_idx;
  logic              ctrl_hit;
  logic              status_hit;
  logic [HALF_W-1:0] ctrl_q [NUM_CTRL];
  logic [1:0]        st_sync;
  logic [HALF_W-1:0] ctrl_rd;

  assign ctrl_idx   = addr_i[ADDR_W-1:2];
  assign ctrl_hit   = (addr_i[1:0] == 2'b00) && (ctrl_idx < NUM_CTRL_L);
  assign status_hit = (addr_i == STATUS_OFF_L);

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_word
    phy_ctl_word #(.HALF_W(HALF_W)) u_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i && ctrl_hit && (ctrl_idx == IDX_W'(g))),
      .wdata_i(wdata_i),
      .q_o    (ctrl_q[g])
    );
  end

  phy_ctl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cal_done_i, dll_ready_i}),
    .q_o   (st_sync)
  );

  always_comb begin
    ctrl_rd = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (ctrl_idx == IDX_W'(i)) ctrl_rd = ctrl_q[i];
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) begin
      rdata_o[HALF_W-1:0] = ctrl_rd;
    end else if (status_hit) begin
      rdata_o[B_ST_CAL] = st_sync[1];
      rdata_o[B_ST_DLL] = st_sync[0];
    end
  end

  assign pwr_up_o     = ctrl_q[IDX_POWER][B_PWR_UP];
  assign dll_en_o     = ctrl_q[IDX_POWER][B_DLL_EN];
  assign drive_sel_o  = ctrl_q[IDX_POWER][B_DRV_LO +: DRV_W];
  assign freq_sel_o   = ctrl_q[IDX_TIMING][B_FREQ_LO +: FREQ_W];
  assign tap_dly_en_o = ctrl_q[IDX_TIMING][B_TAP_EN];
  assign tap_dly_o    = ctrl_q[IDX_TIMING][B_TAP_LO +: TAP_W];
  assign strobe_pd_o  = ctrl_q[IDX_STROBE][B_STRB_PD];
endmodule

// File: rtl/phy_ctl_regs_chk.sv
module phy_ctl_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic [7:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        cal_done_i,
  input logic        dll_ready_i,
  input logic        pwr_up_o,
  input logic        dll_en_o,
  input logic [1:0]  freq_sel_o,
  input logic [2:0]  drive_sel_o,
  input logic        tap_dly_en_o,
  input logic [3:0]  tap_dly_o,
  input logic        strobe_pd_o
);
  logic [13:0] pins;
  assign pins = {pwr_up_o, dll_en_o, freq_sel_o, drive_sel_o, tap_dly_en_o, tap_dly_o, strobe_pd_o};

  AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h18 && !wdata_i[16]) |=> pwr_up_o == $past(pwr_up_o)); // R2

  AST_PWR_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h18 && wdata_i[16]) |=> pwr_up_o == $past(wdata_i[0])); // R4

  AST_TAP_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h00 && wdata_i[26:23] == 4'hf) |=> tap_dly_o == $past(wdata_i[10:7])); // R5

  AST_STRB_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h08 && wdata_i[25]) |=> strobe_pd_o == $past(wdata_i[9])); // R6

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1:0] == 2'b00 && addr_i < 8'h1c) |-> rdata_o[31:16] == 16'h0); // R3

  AST_STATUS_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h20) |-> (rdata_o[6] == $past(cal_done_i, 2) && rdata_o[5] == $past(dll_ready_i, 2))); // R7

  AST_STATUS_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h20) |-> (rdata_o[31:7] == '0 && rdata_o[4:0] == '0)); // R7

  AST_STRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i[1:0] != 2'b00 || addr_i >= 8'h1c)) |=> $stable(pins)); // R8
endmodule

bind phy_ctl_regs phy_ctl_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .cal_done_i(cal_done_i), .dll_ready_i(dll_ready_i),
  .pwr_up_o(pwr_up_o), .dll_en_o(dll_en_o), .freq_sel_o(freq_sel_o),
  .drive_sel_o(drive_sel_o), .tap_dly_en_o(tap_dly_en_o), .tap_dly_o(tap_dly_o),
  .strobe_pd_o(strobe_pd_o)
);

// File: tb/phy_ctl_regs_test.sv
module phy_ctl_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        cal_done_i = 1'b0;
  logic        dll_ready_i = 1'b0;
  logic [31:0] rdata_o;
  logic        pwr_up_o, dll_en_o, tap_dly_en_o, strobe_pd_o;
  logic [1:0]  freq_sel_o;
  logic [2:0]  drive_sel_o;
  logic [3:0]  tap_dly_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] mdl [7];
  logic [1:0]  s1 = '0, s2 = '0;

  phy_ctl_regs uut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (a[1:0] == 2'b00 && a < 8'h1c) return {16'h0, mdl[a[7:2]]};
    if (a == 8'h20) return {25'h0, s2[1], s2[0], 5'h0};
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h exp %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "rdata", rdata_o, exp_rd(addr_i));
    chk("R4", "pwr_up", 32'(pwr_up_o), 32'(mdl[6][0]));
    chk("R4", "dll_en", 32'(dll_en_o), 32'(mdl[6][1]));
    chk("R4", "drive", 32'(drive_sel_o), 32'(mdl[6][6:4]));
    chk("R5", "freq", 32'(freq_sel_o), 32'(mdl[0][13:12]));
    chk("R5", "tap_en", 32'(tap_dly_en_o), 32'(mdl[0][11]));
    chk("R5", "tap", 32'(tap_dly_o), 32'(mdl[0][10:7]));
    chk("R6", "strobe_pd", 32'(strobe_pd_o), 32'(mdl[2][9]));
  endtask

  // called at a falling edge; ends at the next falling edge after comparing
  task automatic step(input string tag, input logic we, input logic [7:0] a,
                      input logic [31:0] wd, input logic cal, input logic dll);
    we_i = we; addr_i = a; wdata_i = wd; cal_done_i = cal; dll_ready_i = dll;
    @(posedge clk_i);
    if (we && a[1:0] == 2'b00 && a < 8'h1c)
      mdl[a[7:2]] = (mdl[a[7:2]] & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
    s2 = s1; s1 = {cal, dll};
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    step(tag, 1'b0, a, 32'h0, cal_done_i, dll_ready_i);
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] wd);
    step(tag, 1'b1, a, wd, cal_done_i, dll_ready_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) mdl[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    for (int i = 0; i < 7; i++) rd("R1", 8'(i * 4));
    rd("R7", 8'h20);
    // R9 / R3 full-mask pattern into every word
    for (int i = 0; i < 7; i++) wr("R9", 8'(i * 4), 32'hffff_a5c3 ^ 32'(i * 16'h1111));
    for (int i = 0; i < 7; i++) rd("R3", 8'(i * 4));
    // R2 partial masks
    wr("R2", 8'h04, 32'h00f0_1234);
    rd("R2", 8'h04);
    wr("R2", 8'h10, 32'h0000_ffff);
    rd("R2", 8'h10);
    wr("R2", 8'h14, 32'h8001_0000);
    rd("R2", 8'h14);
    wr("R2", 8'h0c, 32'h5555_aaaa);
    rd("R2", 8'h0c);
    // R4 power word fields and all drive codes
    wr("R4", 8'h18, 32'h0077_0000);
    for (int c = 0; c < 5; c++) begin
      wr("R4", 8'h18, 32'h0070_0000 | 32'(c << 4));
      rd("R4", 8'h18);
    end
    wr("R4", 8'h18, 32'h0001_0001);
    wr("R4", 8'h18, 32'h0002_0002);
    wr("R4", 8'h18, 32'h0001_0000);
    rd("R4", 8'h18);
    // R5 timing word fields
    wr("R5", 8'h00, 32'hffff_0000);
    for (int f = 0; f < 4; f++) wr("R5", 8'h00, 32'h3000_0000 | 32'(f << 12));
    wr("R5", 8'h00, 32'h0800_0800);
    for (int t = 0; t < 16; t += 5) wr("R5", 8'h00, 32'h0780_0000 | 32'(t << 7));
    rd("R5", 8'h00);
    // R6 strobe pull-down
    wr("R6", 8'h08, 32'h0200_0200);
    rd("R6", 8'h08);
    wr("R6", 8'h08, 32'h0200_0000);
    rd("R6", 8'h08);
    // R7 status synchronizer latency, read continuously
    step("R7", 1'b0, 8'h20, 32'h0, 1'b1, 1'b0);
    step("R7", 1'b0, 8'h20, 32'h0, 1'b1, 1'b1);
    step("R7", 1'b0, 8'h20, 32'h0, 1'b0, 1'b1);
    step("R7", 1'b0, 8'h20, 32'h0, 1'b0, 1'b1);
    step("R7", 1'b0, 8'h20, 32'h0, 1'b1, 1'b0);
    step("R7", 1'b0, 8'h20, 32'h0, 1'b1, 1'b0);
    step("R7", 1'b0, 8'h20, 32'h0, 1'b1, 1'b0);
    // R8 stray writes then read everything back
    wr("R8", 8'h20, 32'hffff_ffff);
    wr("R8", 8'h1c, 32'hffff_ffff);
    wr("R8", 8'h24, 32'hffff_0000);
    wr("R8", 8'h02, 32'hffff_ffff);
    wr("R8", 8'h19, 32'hffff_ffff);
    wr("R8", 8'hfc, 32'hffff_ffff);
    rd("R8", 8'h1c);
    rd("R8", 8'h01);
    rd("R8", 8'h40);
    rd("R7", 8'h20);
    for (int i = 0; i < 7; i++) rd("R8", 8'(i * 4));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule